// File: doc/BRIEF.md
# Powered-Ethernet Port Sequencer

This block steps one power-sourcing Ethernet port through its start-up life. It runs a signature measurement in two back-to-back phases, then a class measurement, then asks for the port's power switch to be turned on. An external analog front end does the actual measurements. The block tells that front end when each phase starts. At the end of each timed window, the block samples the front end's result flags.

The timing base is a one-cycle millisecond tick. The host picks one of three ways of working:
- **Auto**: the whole chain runs unattended.
- **Semiauto**: measurement runs unattended, and a host command is needed to apply power.
- **Manual**: every step waits for a host command.

A port reset command, or an active-low shutdown pin after glitch filtering, forces the port off and back to idle. A glitch-filtered active-low chip reset input acts like the synchronous reset. Single-cycle event pulses feed an interrupt and status block elsewhere on the chip.

Top module: `pse_port_seq`

## Requirements
- R1: After `rst`, `gate_en`, `det_ok`, `class_out`, every start strobe and every event output are 0, and `port_state` is 0 (idle).
- R2: Detection is two phases of `DET_PH_MS` ticks each. `det_ph1_start` and `det_ph2_start` pulse one cycle as each phase begins. `ev_det_done` pulses `2*DET_PH_MS` ticks after `det_ph1_start`, and `det_ok` then holds `sig_valid` as sampled on the last tick.
- R3: A class window lasts `CLS_MS` ticks and begins with a `cls_start` pulse. It ends with an `ev_cls_done` pulse, and `class_out` then holds `cls_code` as sampled on the last tick.
- R4: In auto mode (`mode`=2), the chain runs from idle without commands. `ev_pwr_en` pulses and `gate_en` rises `PON_MS` ticks after `ev_cls_done`.
- R5: In semiauto mode (`mode`=1), detection and classification run without commands. `gate_en` stays 0 until a `cmd_power` pulse arrives after classification.
- R6: In manual mode (`mode`=0, and also the reserved code 3):
  - `cmd_detect` starts detection from idle.
  - After a valid signature, `cmd_class` runs a class window.
  - `cmd_power` turns the port on.
- R7: An invalid signature gives no class event and no power. Manual mode returns to idle. Auto and semiauto wait `BACKOFF_MS` ticks from `ev_det_done` and then start detection again.
- R8: A `cmd_reset` pulse, or a filtered low on `shdn_n`, drops `gate_en` on the next cycle. It also returns the port to idle and clears `det_ok` and `class_out`, and it takes priority over a window ending in the same cycle. While `shdn_n` is held low, no detection starts.
- R9: Low pulses on `shdn_n` or `chip_rst_n` shorter than `FILT_CYC` consecutive clock samples have no effect. A low lasting `FILT_CYC` samples is accepted.
- R10: A filtered low on `chip_rst_n` puts the port in the same state as `rst`, for as long as the low lasts.
- R11: `ev_pwr_good` pulses once each time the port is on and `pwr_good` becomes high. It never pulses while the port is off.
- R12: Commands that do not apply are ignored:
  - `cmd_class` outside manual mode, or outside the wait-for-power state.
  - `cmd_power` anywhere but the wait-for-power state.
  - `cmd_detect` while not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_rst_n | input | 1 | Chip reset, active low, glitch filtered |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mode | input | 2 | 0 manual, 1 semiauto, 2 auto, 3 treated as manual |
| cmd_detect | input | 1 | Host pulse: start detection |
| cmd_class | input | 1 | Host pulse: run a class window (manual) |
| cmd_power | input | 1 | Host pulse: turn the port on |
| cmd_reset | input | 1 | Host pulse: reset this port |
| shdn_n | input | 1 | Port shutdown, active low, glitch filtered |
| sig_valid | input | 1 | Front end: signature within range |
| cls_code | input | CLS_W | Front end: measured class |
| pwr_good | input | 1 | Front end: port voltage is good |
| gate_en | output | 1 | Request to turn on the port power switch |
| det_ph1_start | output | 1 | Pulse: first detection phase begins |
| det_ph2_start | output | 1 | Pulse: second detection phase begins |
| cls_start | output | 1 | Pulse: class window begins |
| port_state | output | 3 | 0 idle, 1/2 detect phases, 3 class, 4 power delay, 5 wait for power, 6 on, 7 back-off |
| det_ok | output | 1 | Last signature result |
| class_out | output | CLS_W | Last class result |
| ev_det_done | output | 1 | Event: detection complete |
| ev_cls_done | output | 1 | Event: classification complete |
| ev_pwr_en | output | 1 | Event: port power enabled |
| ev_pwr_good | output | 1 | Event: power good while on |

## Verification
Two things can land on the same clock edge: the end of the class window and a port reset. In that case the reset must win.

The bench provokes this in auto mode. It counts ticks from the `cls_start` pulse and raises `cmd_reset` in exactly the cycle whose tick closes the window. It then judges the result at the ports: no `ev_cls_done` may appear, `class_out` must stay 0 and the port must not power on. Each phase length is also measured in ticks by watching the strobes and events.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL = 2'd0,
    MODE_SEMI   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } seq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DET1    = 3'd1,
    ST_DET2    = 3'd2,
    ST_CLS     = 3'd3,
    ST_PON     = 3'd4,
    ST_READY   = 3'd5,
    ST_ON      = 3'd6,
    ST_BACKOFF = 3'd7
  } seq_state_e;
endpackage

// File: rtl/pse_low_filter.sv
module pse_low_filter #(
  parameter int FILT_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic in_n,
  output logic active
);
  localparam int CW = $clog2(FILT_CYC + 1);
  logic [CW-1:0] run_q;

  // active only after FILT_CYC consecutive low samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      active <= 1'b0;
    end else if (in_n) begin
      run_q  <= '0;
      active <= 1'b0;
    end else begin
      if (run_q != CW'(FILT_CYC)) run_q <= run_q + 1'b1;
      active <= (run_q >= CW'(FILT_CYC - 1));
    end
  end

  assert_active_needs_low_R9: assert property (@(posedge clk) disable iff (rst)
    active |-> ($past(in_n) == 1'b0));
endmodule

// File: rtl/pse_ms_window.sv
module pse_ms_window #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = tick && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || expire) cnt_q <= '0;
    else if (tick)                cnt_q <= cnt_q + 1'b1;
  end

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit);
endmodule

// File: rtl/pse_seq_fsm.sv
module pse_seq_fsm
  import pse_seq_pkg::*;
#(
  parameter int DET_PH_MS  = 100,
  parameter int CLS_MS     = 12,
  parameter int PON_MS     = 1,
  parameter int BACKOFF_MS = 250,
  parameter int CLS_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic             cmd_detect,
  input  logic             cmd_class,
  input  logic             cmd_power,
  input  logic             cmd_reset,
  input  logic             sig_valid,
  input  logic [CLS_W-1:0] cls_code,
  input  logic             pwr_good,
  output logic             gate_en,
  output logic             det_ph1_start,
  output logic             det_ph2_start,
  output logic             cls_start,
  output logic [2:0]       port_state,
  output logic             det_ok,
  output logic [CLS_W-1:0] class_out,
  output logic             ev_det_done,
  output logic             ev_cls_done,
  output logic             ev_pwr_en,
  output logic             ev_pwr_good
);
  localparam int MAX_AB = (DET_PH_MS > CLS_MS) ? DET_PH_MS : CLS_MS;
  localparam int MAX_CD = (PON_MS > BACKOFF_MS) ? PON_MS : BACKOFF_MS;
  localparam int MAXW   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXW + 1);

  seq_state_e st_q, st_nxt;
  logic [CW-1:0] limit;
  logic expire, port_rst, is_auto, is_manual, good_q, good_now;

  assign port_rst  = hold | cmd_reset;
  assign is_auto   = (mode == MODE_AUTO);
  assign is_manual = (mode == MODE_MANUAL) || (mode == MODE_RSVD);

  always_comb begin
    case (st_q)
      ST_DET1, ST_DET2: limit = CW'(DET_PH_MS);
      ST_CLS:           limit = CW'(CLS_MS);
      ST_PON:           limit = CW'(PON_MS);
      ST_BACKOFF:       limit = CW'(BACKOFF_MS);
      default:          limit = CW'(1);
    endcase
  end

  pse_ms_window #(.CW(CW)) win_i (
    .clk(clk), .rst(rst), .restart(st_nxt != st_q), .tick(tick),
    .limit(limit), .expire(expire)
  );

  always_comb begin
    st_nxt = st_q;
    if (port_rst) st_nxt = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE:    if (!is_manual || cmd_detect) st_nxt = ST_DET1;
        ST_DET1:    if (expire) st_nxt = ST_DET2;
        ST_DET2:    if (expire) begin
                      if (sig_valid) st_nxt = is_manual ? ST_READY : ST_CLS;
                      else           st_nxt = is_manual ? ST_IDLE : ST_BACKOFF;
                    end
        ST_CLS:     if (expire) st_nxt = is_auto ? ST_PON : ST_READY;
        ST_PON:     if (expire) st_nxt = ST_ON;
        ST_READY:   if (is_manual && cmd_class) st_nxt = ST_CLS;
                    else if (cmd_power)         st_nxt = ST_ON;
        ST_BACKOFF: if (expire) st_nxt = is_manual ? ST_IDLE : ST_DET1;
        default:    st_nxt = st_q;
      endcase
    end
  end

  assign good_now = (st_nxt == ST_ON) && pwr_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      gate_en <= 1'b0;
      det_ph1_start <= 1'b0;
      det_ph2_start <= 1'b0;
      cls_start <= 1'b0;
      det_ok <= 1'b0;
      class_out <= '0;
      ev_det_done <= 1'b0;
      ev_cls_done <= 1'b0;
      ev_pwr_en <= 1'b0;
      ev_pwr_good <= 1'b0;
      good_q <= 1'b0;
    end else begin
      st_q          <= st_nxt;
      gate_en       <= (st_nxt == ST_ON);
      det_ph1_start <= (st_nxt == ST_DET1) && (st_q != ST_DET1);
      det_ph2_start <= (st_nxt == ST_DET2) && (st_q == ST_DET1);
      cls_start     <= (st_nxt == ST_CLS) && (st_q != ST_CLS);
      ev_det_done   <= !port_rst && (st_q == ST_DET2) && (st_nxt != ST_DET2);
      ev_cls_done   <= !port_rst && (st_q == ST_CLS) && (st_nxt != ST_CLS);
      ev_pwr_en     <= (st_nxt == ST_ON) && (st_q != ST_ON);
      ev_pwr_good   <= good_now && !good_q;
      good_q        <= good_now;
      if (port_rst || (st_nxt == ST_DET1 && st_q != ST_DET1)) begin
        det_ok    <= 1'b0;
        class_out <= '0;
      end else begin
        if (st_q == ST_DET2 && st_nxt != ST_DET2) det_ok <= sig_valid;
        if (st_q == ST_CLS && st_nxt != ST_CLS) class_out <= cls_code;
      end
    end
  end

  assign port_state = st_q;

  assert_events_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_det_done, ev_cls_done, ev_pwr_en}));
  assert_ph2_after_ph1_R2: assert property (@(posedge clk) disable iff (rst)
    det_ph2_start |-> ($past(port_state) == 3'd1));
  assert_class_needs_sig_R7: assert property (@(posedge clk) disable iff (rst)
    ev_cls_done |-> det_ok);
  assert_gate_rise_event_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> ev_pwr_en);
  assert_ready_needs_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_pwr_en && $past(port_state) == 3'd5) |-> $past(cmd_power));
  assert_hold_forces_off_R8: assert property (@(posedge clk) disable iff (rst)
    (hold || cmd_reset) |=> (!gate_en && !det_ph1_start));
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_seq_pkg::*;
#(
  parameter int DET_PH_MS  = 100,
  parameter int CLS_MS     = 12,
  parameter int PON_MS     = 1,
  parameter int BACKOFF_MS = 250,
  parameter int FILT_CYC   = 125,
  parameter int CLS_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_rst_n,
  input  logic             ms_tick,
  input  logic [1:0]       mode,
  input  logic             cmd_detect,
  input  logic             cmd_class,
  input  logic             cmd_power,
  input  logic             cmd_reset,
  input  logic             shdn_n,
  input  logic             sig_valid,
  input  logic [CLS_W-1:0] cls_code,
  input  logic             pwr_good,
  output logic             gate_en,
  output logic             det_ph1_start,
  output logic             det_ph2_start,
  output logic             cls_start,
  output logic [2:0]       port_state,
  output logic             det_ok,
  output logic [CLS_W-1:0] class_out,
  output logic             ev_det_done,
  output logic             ev_cls_done,
  output logic             ev_pwr_en,
  output logic             ev_pwr_good
);
  localparam int NFILT = 2;   // 0: shutdown pin, 1: chip reset pin
  logic [NFILT-1:0] raw_n, held;
  logic seq_rst;

  assign raw_n = {chip_rst_n, shdn_n};

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    pse_low_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk(clk), .rst(rst), .in_n(raw_n[g]), .active(held[g])
    );
  end

  assign seq_rst = rst | held[1];

  pse_seq_fsm #(
    .DET_PH_MS(DET_PH_MS), .CLS_MS(CLS_MS), .PON_MS(PON_MS),
    .BACKOFF_MS(BACKOFF_MS), .CLS_W(CLS_W)
  ) fsm_i (
    .clk(clk), .rst(seq_rst), .hold(held[0]), .tick(ms_tick), .mode(mode),
    .cmd_detect(cmd_detect), .cmd_class(cmd_class), .cmd_power(cmd_power),
    .cmd_reset(cmd_reset), .sig_valid(sig_valid), .cls_code(cls_code),
    .pwr_good(pwr_good), .gate_en(gate_en), .det_ph1_start(det_ph1_start),
    .det_ph2_start(det_ph2_start), .cls_start(cls_start),
    .port_state(port_state), .det_ok(det_ok), .class_out(class_out),
    .ev_det_done(ev_det_done), .ev_cls_done(ev_cls_done),
    .ev_pwr_en(ev_pwr_en), .ev_pwr_good(ev_pwr_good)
  );
endmodule

// File: tb/pse_port_seq_tb.sv
module pse_port_seq_tb_top;
  localparam int DPH = 3, CLS = 2, PON = 1, BOFF = 4, FILT = 4, TICKCYC = 16;
  localparam int NV = 7;
  // fields: mode[8:7] valid[6] code[5:3] exp_gate[2] exp_cls[1] exp_detok[0]
  localparam logic [8:0] VEC [NV] = '{
    {2'd2, 1'b1, 3'd3, 3'b111},
    {2'd1, 1'b1, 3'd1, 3'b111},
    {2'd0, 1'b1, 3'd4, 3'b111},
    {2'd2, 1'b0, 3'd2, 3'b000},
    {2'd0, 1'b0, 3'd6, 3'b000},
    {2'd3, 1'b1, 3'd0, 3'b111},
    {2'd1, 1'b0, 3'd5, 3'b000}
  };

  logic clk = 0, rst = 1, chip_rst_n = 1, ms_tick = 0;
  logic [1:0] mode = 0;
  logic cmd_detect = 0, cmd_class = 0, cmd_power = 0, cmd_reset = 0;
  logic shdn_n = 1, sig_valid = 0, pwr_good = 0;
  logic [2:0] cls_code = 0;
  logic gate_en, ph1, ph2, cls_st, det_ok, ev_det, ev_cls, ev_pwr, ev_pg;
  logic [2:0] port_state, class_out;

  int checks = 0, failures = 0, div = 0;
  int n_cls = 0, n_pg = 0, n_ph1 = 0;
  int d_cnt = 0, q_cnt = 0, c_cnt = 0, p_cnt = 0, b_cnt = 0;
  int last_det = -1, last_ph1 = -1, last_cls = -1, last_pon = -1, last_boff = -1;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    ms_tick <= (div == TICKCYC - 1);
    div <= (div == TICKCYC - 1) ? 0 : div + 1;
  end

  pse_port_seq #(.DET_PH_MS(DPH), .CLS_MS(CLS), .PON_MS(PON),
    .BACKOFF_MS(BOFF), .FILT_CYC(FILT), .CLS_W(3)) dut_i (
    .clk(clk), .rst(rst), .chip_rst_n(chip_rst_n), .ms_tick(ms_tick),
    .mode(mode), .cmd_detect(cmd_detect), .cmd_class(cmd_class),
    .cmd_power(cmd_power), .cmd_reset(cmd_reset), .shdn_n(shdn_n),
    .sig_valid(sig_valid), .cls_code(cls_code), .pwr_good(pwr_good),
    .gate_en(gate_en), .det_ph1_start(ph1), .det_ph2_start(ph2),
    .cls_start(cls_st), .port_state(port_state), .det_ok(det_ok),
    .class_out(class_out), .ev_det_done(ev_det), .ev_cls_done(ev_cls),
    .ev_pwr_en(ev_pwr), .ev_pwr_good(ev_pg));

  // tick-interval and event monitors
  always @(negedge clk) begin
    if (ev_cls) n_cls++;
    if (ev_pg) n_pg++;
    if (ph1) n_ph1++;
    if (ph1) d_cnt = int'(ms_tick); else if (ev_det) last_det = d_cnt; else d_cnt += int'(ms_tick);
    if (ph1) q_cnt = int'(ms_tick); else if (ph2) last_ph1 = q_cnt; else q_cnt += int'(ms_tick);
    if (cls_st) c_cnt = int'(ms_tick); else if (ev_cls) last_cls = c_cnt; else c_cnt += int'(ms_tick);
    if (ev_cls) p_cnt = int'(ms_tick); else if (ev_pwr) last_pon = p_cnt; else p_cnt += int'(ms_tick);
    if (ev_det) b_cnt = int'(ms_tick); else if (ph1) last_boff = b_cnt; else b_cnt += int'(ms_tick);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ms(input int n);
    step(n * TICKCYC);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    cmd_reset = 1; step(1); cmd_reset = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 0;
    step(1);
    // R1 reset state
    chk("R1 gate", int'(gate_en), 0);
    chk("R1 state", int'(port_state), 0);
    chk("R1 class", int'(class_out), 0);
    chk("R1 det_ok", int'(det_ok), 0);
    chk("R1 events", int'({ev_det, ev_cls, ev_pwr, ev_pg, ph1}), 0);

    // table walk: R2-R7, R12
    for (int i = 0; i < NV; i++) begin
      int cls0;
      bit valid;
      mode = VEC[i][8:7];
      valid = VEC[i][6];
      sig_valid = valid;
      cls_code = VEC[i][5:3];
      pulse_reset();
      cls0 = n_cls;
      cmd_detect = 1; step(1); cmd_detect = 0;
      ms(12);
      cmd_class = 1; step(1); cmd_class = 0;
      ms(4);
      chk("R5 gate before power cmd", int'(gate_en), (mode == 2 && valid) ? 1 : 0);
      cmd_power = 1; step(1); cmd_power = 0;
      ms(3);
      chk("R4 R5 R6 R12 gate", int'(gate_en), int'(VEC[i][2]));
      chk("R3 R7 class event seen", int'(n_cls != cls0), int'(VEC[i][1]));
      chk("R2 det_ok", int'(det_ok), int'(VEC[i][0]));
      chk("R3 class_out", int'(class_out), valid ? int'(VEC[i][5:3]) : 0);
    end

    // R2 R3 R4 tick timing in auto mode
    mode = 2; sig_valid = 1; cls_code = 5;
    pulse_reset();
    ms(12);
    chk("R2 phase1 ticks", last_ph1, DPH);
    chk("R2 detect ticks", last_det, 2 * DPH);
    chk("R3 class ticks", last_cls, CLS);
    chk("R4 power delay ticks", last_pon, PON);

    // R11 power good events
    begin
      int pg0;
      pg0 = n_pg;
      pwr_good = 1; step(3);
      chk("R11 first good", n_pg - pg0, 1);
      pwr_good = 0; step(2); pwr_good = 1; step(3);
      chk("R11 second good", n_pg - pg0, 2);
      mode = 0; pulse_reset(); step(2);
      pwr_good = 0; step(2); pwr_good = 1; step(3);
      chk("R11 none while off", n_pg - pg0, 2);
      pwr_good = 0;
    end

    // R7 back-off in auto mode
    begin
      int cls0;
      cls0 = n_cls;
      mode = 2; sig_valid = 0;
      pulse_reset();
      ms(16);
      chk("R7 backoff ticks", last_boff, BOFF);
      chk("R7 no class event", n_cls - cls0, 0);
    end

    // R9 R8 shutdown pin
    sig_valid = 1; cls_code = 2;
    pulse_reset();
    ms(12);
    chk("R4 on before shutdown", int'(gate_en), 1);
    shdn_n = 0; step(FILT - 1); shdn_n = 1; step(5);
    chk("R9 short shutdown ignored", int'(gate_en), 1);
    shdn_n = 0; step(FILT + 2);
    chk("R8 shutdown gate", int'(gate_en), 0);
    chk("R8 shutdown state", int'(port_state), 0);
    chk("R8 shutdown class", int'(class_out), 0);
    begin
      int p0;
      p0 = n_ph1;
      ms(3);
      chk("R8 no detect while held", n_ph1 - p0, 0);
      shdn_n = 1;
      ms(2);
      chk("R8 detect after release", int'(n_ph1 > p0), 1);
    end

    // R9 R10 chip reset pin
    ms(12);
    chk("R4 on before chip reset", int'(gate_en), 1);
    chip_rst_n = 0; step(FILT - 1); chip_rst_n = 1; step(5);
    chk("R9 short chip reset ignored", int'(gate_en), 1);
    chip_rst_n = 0; step(FILT + 2);
    chk("R10 chip reset gate", int'(gate_en), 0);
    chk("R10 chip reset state", int'(port_state), 0);
    chk("R10 chip reset det_ok", int'(det_ok), 0);
    chk("R10 chip reset class", int'(class_out), 0);
    chip_rst_n = 1;
    step(2);

    // R8 reset in the same cycle as the end of the class window
    begin
      int n, cls0, guard;
      pulse_reset();
      guard = 0;
      while (!cls_st && guard < 2000) begin step(1); guard++; end
      n = 0;
      forever begin
        if (ms_tick) n++;
        if (n == CLS) break;
        step(1);
      end
      cls0 = n_cls;
      cmd_reset = 1; step(1); cmd_reset = 0;
      step(3);
      chk("R8 reset beats class end: event", n_cls - cls0, 0);
      chk("R8 reset beats class end: class", int'(class_out), 0);
      chk("R8 reset beats class end: gate", int'(gate_en), 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule